// File: doc/BRIEF.md
# PCM Serial Clock and Framing Engine

This block drives the serial side of a two-direction PCM audio port that always acts as master. It derives a bit clock from one of two source clocks through a 9-bit divider. It counts bit clocks into frames of programmable length and marks the first bit clock of each frame with a one-bit-clock frame-sync pulse. At each frame start it takes one 16-bit transmit sample through a valid/ready handshake and shifts it out MSB first. In the same frame it shifts a 16-bit sample in from the receive line and presents it on a one-cycle valid strobe.

Both source clocks are modelled as clock enables in the `clk` domain. The bus clock is `clk` itself, so every cycle counts. The audio clock is a one-cycle strobe `aud_tick`. Each direction has a bit that places its MSB either in the sync bit clock or in the bit clock after it. The idle-clock bit picks one of two behaviours when both directions are off: the bit clock keeps running, or it is gated off and held low. Divider values are taken only at frame boundaries, or while the clock is stopped.

Top module: `pcm_serial_engine`

## Requirements
- R1: The bit-clock half period is `bclk_div`+1 selected source ticks, so the full period is 2×(`bclk_div`+1) ticks. `bclk` starts low after a stop.
- R2: With `src_sel`=0 every `clk` cycle is a source tick. With `src_sel`=1 only cycles with `aud_tick`=1 count.
- R3: A frame lasts `sync_div`+1 bit clocks. `fsync` rises together with the first `bclk` rising edge of a frame and stays high for exactly one bit-clock period.
- R4: New values on `bclk_div` and `sync_div` take effect only at the next frame start. A frame in progress keeps the timing it started with.
- R5: `bclk` and `fsync` are held low when `sclk_en`=0, and after reset. With `idle_run`=0 they are also held low when neither direction is active. With `idle_run`=1 the clock runs while both directions are idle.
- R6: Transmit sends 16 bits MSB first, changing `sd_out` with the `bclk` rising edge. With `tx_msb_late`=0 the MSB is in the sync bit clock. With `tx_msb_late`=1 it is in the next bit clock. `sd_out` is 0 in all other bit positions.
- R7: When transmit is active, `tx_ready` is high for one cycle at each frame start and the sample is taken if `tx_valid` is high. If `tx_valid` is low, the frame sends zeros and `tx_starve` pulses for one cycle.
- R8: Receive samples `sd_in` on the `bclk` falling edge, 16 bits MSB first. `rx_msb_late` places the MSB the same way as `tx_msb_late` does for transmit. `rx_valid` pulses for one cycle with the word after its last bit.
- R9: A direction is active only when `port_en` and its own enable are both 1. An inactive transmitter holds `sd_out` at 0 and never raises `tx_ready`. An inactive receiver never raises `rx_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, which also serves as the bus source clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_sel | input | 1 | 0: count every clk cycle; 1: count aud_tick strobes |
| aud_tick | input | 1 | One-cycle strobe of the audio source clock |
| sclk_en | input | 1 | Serial clock enable |
| idle_run | input | 1 | 1: bit clock runs while both directions are idle |
| port_en | input | 1 | Global port enable |
| tx_en | input | 1 | Transmit direction enable |
| rx_en | input | 1 | Receive direction enable |
| tx_msb_late | input | 1 | Transmit MSB one bit clock after sync |
| rx_msb_late | input | 1 | Receive MSB one bit clock after sync |
| bclk_div | input | 9 | Bit-clock divider value |
| sync_div | input | 9 | Frame length minus one, in bit clocks |
| tx_data | input | 16 | Transmit sample |
| tx_valid | input | 1 | Transmit sample available |
| tx_ready | output | 1 | Transmit sample taken this cycle |
| tx_starve | output | 1 | One-cycle strobe: frame started with no sample |
| sd_in | input | 1 | Serial receive data |
| bclk | output | 1 | Bit clock |
| fsync | output | 1 | Frame sync |
| sd_out | output | 1 | Serial transmit data |
| rx_data | output | 16 | Received sample |
| rx_valid | output | 1 | One-cycle strobe: rx_data holds a new sample |

## Verification
The assertions take for granted that `aud_tick` is a single-cycle strobe. They also assume that a frame is long enough for a full 16-bit receive window, so a receive strobe never repeats on consecutive cycles. The bench generates `aud_tick` once every three cycles. It changes divider and direction settings mostly while `sclk_en` is low. The one exception is the reload test, which changes the dividers on purpose in the middle of a frame. Every loopback vector uses a frame of at least seventeen bit clocks, so the whole shifted word fits inside one frame.

// File: rtl/pcm_eng_pkg.sv
// Package: shared widths and the per-direction configuration type.
package pcm_eng_pkg;
    localparam int DIV_BITS    = 9;
    localparam int SAMPLE_BITS = 16;

    // Per-direction settings, resolved in the top module.
    typedef struct packed {
        logic active;    // port enable AND direction enable
        logic msb_late;  // MSB one bit clock after the sync bit clock
    } dir_cfg_t;
endpackage

// File: rtl/pcm_bclk_div.sv
// pcm_bclk_div: divides source ticks down to the bit clock.
// Assumes: tick is a clock enable in the clk domain. The divider value is
// taken while stopped and again whenever reload is high (frame start).
module pcm_bclk_div #(
    parameter int DIV_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  logic             reload,
    input  logic [DIV_W-1:0] div_in,
    output logic             bclk,
    output logic             rise,
    output logic             fall
);
    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] cur_q;
    logic             wrap;

    assign wrap = run && tick && (cnt_q == cur_q);
    assign rise = wrap && !bclk;
    assign fall = wrap && bclk;

    // Half-period counter, bit-clock toggle and held divider value.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q <= '0;
            cur_q <= div_in;
            bclk  <= 1'b0;
        end else begin
            if (tick) begin
                if (cnt_q == cur_q) begin
                    cnt_q <= '0;
                    bclk  <= ~bclk;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
            if (reload) begin
                cur_q <= div_in;
            end
        end
    end

    // R1: the half-period count never runs past the held divider.
    p_cnt_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt_q <= cur_q));

    // R5: a stopped clock comes back low.
    p_stop_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !bclk);
endmodule

// File: rtl/pcm_frame_ctr.sv
// pcm_frame_ctr: counts bit clocks into frames and drives frame sync.
// Assumes: rise is a one-cycle strobe before each bclk rising edge. The
// frame length is taken while stopped and again at each frame start.
module pcm_frame_ctr #(
    parameter int DIV_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             rise,
    input  logic [DIV_W-1:0] sync_in,
    output logic             fsync,
    output logic             fstart,
    output logic [DIV_W-1:0] pos,
    output logic [DIV_W-1:0] pos_next
);
    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] cur_q;

    assign fstart   = rise && (cnt_q == cur_q);
    assign pos      = cnt_q;
    assign pos_next = fstart ? '0 : cnt_q + 1'b1;

    // Bit position within the frame and the one-bit sync pulse.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q <= sync_in;
            cur_q <= sync_in;
            fsync <= 1'b0;
        end else if (rise) begin
            if (cnt_q == cur_q) begin
                cnt_q <= '0;
                cur_q <= sync_in;
                fsync <= 1'b1;
            end else begin
                cnt_q <= cnt_q + 1'b1;
                fsync <= 1'b0;
            end
        end
    end

    // R3: sync is only ever high in bit position zero.
    p_fsync_pos_r3: assert property (@(posedge clk) disable iff (!rst_n)
        fsync |-> (pos == '0));

    // R3: the position never passes the held frame length.
    p_pos_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt_q <= cur_q));
endmodule

// File: rtl/pcm_tx_shift.sv
// pcm_tx_shift: takes a sample at frame start and drives it MSB first.
// Assumes: fstart and rise are strobes from the framing logic, and
// pos_next is the bit position that the coming rising edge starts.
module pcm_tx_shift
    import pcm_eng_pkg::*;
#(
    parameter int SAMPLE_W = 16,
    parameter int DIV_W    = 9
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                run,
    input  dir_cfg_t            cfg,
    input  logic                rise,
    input  logic                fstart,
    input  logic [DIV_W-1:0]    pos_next,
    input  logic [SAMPLE_W-1:0] tx_data,
    input  logic                tx_valid,
    output logic                tx_ready,
    output logic                tx_starve,
    output logic                sd_out
);
    localparam int IDX_W = $clog2(SAMPLE_W);

    logic [SAMPLE_W-1:0] word_q;
    logic [SAMPLE_W-1:0] word_now;
    logic [DIV_W-1:0]    late_w;
    logic [DIV_W-1:0]    off;
    logic                in_win;
    logic [IDX_W-1:0]    bit_sel;

    assign tx_ready = fstart && cfg.active;
    assign word_now = fstart ? ((cfg.active && tx_valid) ? tx_data : '0) : word_q;
    assign late_w   = {{(DIV_W-1){1'b0}}, cfg.msb_late};
    assign off      = pos_next - late_w;
    assign in_win   = (pos_next >= late_w) && (off < DIV_W'(SAMPLE_W));
    assign bit_sel  = IDX_W'(SAMPLE_W - 1) - off[IDX_W-1:0];

    // Sample capture, starve strobe and the serial output bit.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            word_q    <= '0;
            tx_starve <= 1'b0;
            sd_out    <= 1'b0;
        end else begin
            tx_starve <= fstart && cfg.active && !tx_valid;
            if (fstart) begin
                word_q <= word_now;
            end
            if (!cfg.active) begin
                sd_out <= 1'b0;
            end else if (rise) begin
                sd_out <= in_win ? word_now[bit_sel] : 1'b0;
            end
        end
    end

    // R7: a starved frame holds an all-zero word.
    p_starve_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        tx_starve |-> (word_q == '0));

    // R9: an inactive transmitter keeps the line low.
    p_line_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!cfg.active) |-> !sd_out);
endmodule

// File: rtl/pcm_rx_shift.sv
// pcm_rx_shift: samples the receive line on falling edges into a word.
// Assumes: fall is a one-cycle strobe before each bclk falling edge, and pos
// is the current bit position in the frame.
module pcm_rx_shift
    import pcm_eng_pkg::*;
#(
    parameter int SAMPLE_W = 16,
    parameter int DIV_W    = 9
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                run,
    input  dir_cfg_t            cfg,
    input  logic                fall,
    input  logic [DIV_W-1:0]    pos,
    input  logic                sd_in,
    output logic [SAMPLE_W-1:0] rx_data,
    output logic                rx_valid
);
    logic [SAMPLE_W-2:0] sh_q;
    logic [DIV_W-1:0]    late_w;
    logic [DIV_W-1:0]    off;
    logic                in_win;
    logic                last_bit;

    assign late_w   = {{(DIV_W-1){1'b0}}, cfg.msb_late};
    assign off      = pos - late_w;
    assign in_win   = (pos >= late_w) && (off < DIV_W'(SAMPLE_W));
    assign last_bit = (off == DIV_W'(SAMPLE_W - 1));

    // Shift register and the shifted-in word with its strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q     <= '0;
            rx_data  <= '0;
            rx_valid <= 1'b0;
        end else if (!run) begin
            sh_q     <= '0;
            rx_valid <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            if (fall && cfg.active && in_win) begin
                sh_q <= {sh_q[SAMPLE_W-3:0], sd_in};
                if (last_bit) begin
                    rx_data  <= {sh_q, sd_in};
                    rx_valid <= 1'b1;
                end
            end
        end
    end

    // R8: a received word is flagged for one cycle only.
    p_valid_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    // R9: a word is only delivered by an active receiver.
    p_valid_active_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> $past(cfg.active));
endmodule

// File: rtl/pcm_serial_engine.sv
// pcm_serial_engine: master-mode PCM bit clock, frame sync and serial shifter.
// Assumes: aud_tick is a one-cycle strobe in the clk domain; the bus source
// clock is clk itself.
module pcm_serial_engine
    import pcm_eng_pkg::*;
#(
    parameter int DIV_W    = DIV_BITS,
    parameter int SAMPLE_W = SAMPLE_BITS
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                src_sel,
    input  logic                aud_tick,
    input  logic                sclk_en,
    input  logic                idle_run,
    input  logic                port_en,
    input  logic                tx_en,
    input  logic                rx_en,
    input  logic                tx_msb_late,
    input  logic                rx_msb_late,
    input  logic [DIV_W-1:0]    bclk_div,
    input  logic [DIV_W-1:0]    sync_div,
    input  logic [SAMPLE_W-1:0] tx_data,
    input  logic                tx_valid,
    output logic                tx_ready,
    output logic                tx_starve,
    input  logic                sd_in,
    output logic                bclk,
    output logic                fsync,
    output logic                sd_out,
    output logic [SAMPLE_W-1:0] rx_data,
    output logic                rx_valid
);
    dir_cfg_t         tx_cfg;
    dir_cfg_t         rx_cfg;
    logic             tick;
    logic             run;
    logic             rise;
    logic             fall;
    logic             fstart;
    logic [DIV_W-1:0] pos;
    logic [DIV_W-1:0] pos_next;

    // Source-clock select and the run condition for the clock generator.
    always_comb begin
        tick          = src_sel ? aud_tick : 1'b1;
        tx_cfg.active = port_en && tx_en;
        tx_cfg.msb_late = tx_msb_late;
        rx_cfg.active = port_en && rx_en;
        rx_cfg.msb_late = rx_msb_late;
        run = sclk_en && (idle_run || tx_cfg.active || rx_cfg.active);
    end

    pcm_bclk_div #(.DIV_W(DIV_W)) u_div (
        .clk(clk), .rst_n(rst_n), .run(run), .tick(tick), .reload(fstart),
        .div_in(bclk_div), .bclk(bclk), .rise(rise), .fall(fall)
    );

    pcm_frame_ctr #(.DIV_W(DIV_W)) u_frame (
        .clk(clk), .rst_n(rst_n), .run(run), .rise(rise), .sync_in(sync_div),
        .fsync(fsync), .fstart(fstart), .pos(pos), .pos_next(pos_next)
    );

    pcm_tx_shift #(.SAMPLE_W(SAMPLE_W), .DIV_W(DIV_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .run(run), .cfg(tx_cfg), .rise(rise),
        .fstart(fstart), .pos_next(pos_next), .tx_data(tx_data),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_starve(tx_starve),
        .sd_out(sd_out)
    );

    pcm_rx_shift #(.SAMPLE_W(SAMPLE_W), .DIV_W(DIV_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .run(run), .cfg(rx_cfg), .fall(fall),
        .pos(pos), .sd_in(sd_in), .rx_data(rx_data), .rx_valid(rx_valid)
    );

    // R5: once stopped, both clock outputs are low.
    p_stopped_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!run) |-> (!fsync && !bclk));

    // R7: a starve strobe never follows an accepted sample.
    p_starve_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        tx_starve |-> !$past(tx_valid));
endmodule

// File: tb/sim_pcm_serial_engine.sv
`timescale 1ns/1ps
module sim_pcm_serial_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        src_sel = 1'b0, aud_tick = 1'b0, sclk_en = 1'b0, idle_run = 1'b0;
    logic        port_en = 1'b0, tx_en = 1'b0, rx_en = 1'b0;
    logic        tx_msb_late = 1'b0, rx_msb_late = 1'b0;
    logic [8:0]  bclk_div = 9'd1, sync_div = 9'd31;
    logic [15:0] tx_data = 16'h0;
    logic        tx_valid = 1'b0;
    logic        tx_ready, tx_starve, bclk, fsync, sd_out, rx_valid;
    logic [15:0] rx_data;
    logic        sd_in;
    int          checks = 0, fails = 0;

    assign sd_in = sd_out;   // loopback

    always #5 clk = ~clk;

    pcm_serial_engine u0 (
        .clk(clk), .rst_n(rst_n), .src_sel(src_sel), .aud_tick(aud_tick),
        .sclk_en(sclk_en), .idle_run(idle_run), .port_en(port_en),
        .tx_en(tx_en), .rx_en(rx_en), .tx_msb_late(tx_msb_late),
        .rx_msb_late(rx_msb_late), .bclk_div(bclk_div), .sync_div(sync_div),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .tx_starve(tx_starve), .sd_in(sd_in), .bclk(bclk), .fsync(fsync),
        .sd_out(sd_out), .rx_data(rx_data), .rx_valid(rx_valid)
    );

    // Audio source strobe: one cycle in every three.
    initial begin
        int ph = 0;
        forever begin
            @(posedge clk); #1;
            aud_tick = (ph == 2);
            ph = (ph == 2) ? 0 : ph + 1;
        end
    end

    // {div[9], sync[9], src, tx_late, rx_late, data[16]}
    localparam logic [36:0] VEC [6] = '{
        {9'd1, 9'd31, 1'b0, 1'b0, 1'b0, 16'hA5C3},
        {9'd0, 9'd16, 1'b0, 1'b1, 1'b1, 16'h1234},
        {9'd2, 9'd20, 1'b1, 1'b0, 1'b0, 16'hF00F},
        {9'd1, 9'd24, 1'b0, 1'b0, 1'b1, 16'h8001},
        {9'd3, 9'd17, 1'b0, 1'b1, 1'b0, 16'h8001},
        {9'd0, 9'd63, 1'b1, 1'b1, 1'b1, 16'h5A5A}
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Stop the clock, load settings, restart with both directions on.
    task automatic setup(input logic [8:0] dv, input logic [8:0] sy, input logic sr,
                         input logic tl, input logic rl, input logic [15:0] d);
        @(posedge clk); #1;
        sclk_en = 1'b0;
        bclk_div = dv; sync_div = sy; src_sel = sr;
        tx_msb_late = tl; rx_msb_late = rl; tx_data = d; tx_valid = 1'b1;
        idle_run = 1'b0; port_en = 1'b1; tx_en = 1'b1; rx_en = 1'b1;
        @(posedge clk); #1;
        sclk_en = 1'b1;
    endtask

    task automatic wait_rx(output logic [15:0] w);
        do @(negedge clk); while (!rx_valid);
        w = rx_data;
    endtask

    task automatic wait_bclk_rise(output int cyc);
        logic pb = bclk;
        bit   hit = 0;
        cyc = 0;
        while (!hit) begin
            @(negedge clk);
            cyc++;
            if (bclk && !pb) hit = 1;
            pb = bclk;
        end
    endtask

    task automatic wait_fsync_rise();
        logic pf = fsync;
        bit   hit = 0;
        while (!hit) begin
            @(negedge clk);
            if (fsync && !pf) hit = 1;
            pf = fsync;
        end
    endtask

    task automatic bclk_period(output int c);
        int dummy;
        wait_bclk_rise(dummy);
        wait_bclk_rise(c);
    endtask

    task automatic frame_len(output int n);
        logic pf = fsync, pb = bclk;
        int   st = 0;
        n = 0;
        while (st < 2) begin
            @(negedge clk);
            if (st == 1 && bclk && !pb) n++;
            if (fsync && !pf) st++;
            pf = fsync; pb = bclk;
        end
    endtask

    // Counts events over one frame, from one sync rise to the next.
    task automatic frame_counts(output int n_starve, output int n_ready,
                                output int n_ones, output int n_rxv);
        logic pf = fsync;
        int   st = 0;
        n_starve = 0; n_ready = 0; n_ones = 0; n_rxv = 0;
        while (st < 2) begin
            @(negedge clk);
            if (fsync && !pf) st++;
            pf = fsync;
            if (st == 1) begin
                n_starve += int'(tx_starve);
                n_ready  += int'(tx_ready);
                n_ones   += int'(sd_out);
                n_rxv    += int'(rx_valid);
            end
        end
    endtask

    task automatic finish_run();
        $display("  %0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int          per, fl, a, b, c, e;
        logic [15:0] w;

        // Reset state (R5): clock outputs low even when enabled during reset.
        sclk_en = 1'b1; idle_run = 1'b1; port_en = 1'b1; tx_en = 1'b1;
        repeat (6) @(posedge clk);
        @(negedge clk);
        chk("R5 reset outputs", {bclk, fsync, sd_out, rx_valid, tx_starve}, 0);
        #1 rst_n = 1'b1;

        // Vector table: loopback with period, frame and data checks.
        for (int i = 0; i < 6; i++) begin
            logic [36:0] v = VEC[i];
            logic [15:0] d = v[15:0];
            logic        rl = v[16], tl = v[17], sr = v[18];
            logic [8:0]  sy = v[27:19], dv = v[36:28];
            logic [15:0] exp_w;
            setup(dv, sy, sr, tl, rl, d);
            exp_w = (tl == rl) ? d : (tl == 1'b0 ? {d[14:0], 1'b0} : {1'b0, d[15:1]});
            wait_rx(w);
            wait_rx(w);
            chk("R6/R8 loopback word", int'(w), int'(exp_w));
            bclk_period(per);
            chk(sr ? "R2 audio-tick bclk period" : "R1 bclk period",
                per, 2 * (int'(dv) + 1) * (sr ? 3 : 1));
            frame_len(fl);
            chk("R3 frame length", fl, int'(sy) + 1);
        end

        // R6: MSB placement relative to sync, both settings.
        for (int tl = 0; tl < 2; tl++) begin
            int v0, v1;
            setup(9'd1, 9'd31, 1'b0, tl[0], 1'b0, 16'h8000);
            wait_fsync_rise();
            v0 = int'(sd_out);
            wait_bclk_rise(per);
            v1 = int'(sd_out);
            chk("R6 sd_out in sync bit", v0, tl == 0 ? 1 : 0);
            chk("R6 sd_out in bit after sync", v1, tl == 0 ? 0 : 1);
        end

        // R7: starved frame sends zeros and strobes once.
        setup(9'd0, 9'd31, 1'b0, 1'b0, 1'b0, 16'hFFFF);
        #1 tx_valid = 1'b0;
        wait_fsync_rise();
        frame_counts(a, b, c, e);
        chk("R7 starve strobes per frame", a, 1);
        chk("R7 ready strobes per frame", b, 1);
        chk("R7 ones sent while starved", c, 0);

        // R9: port disabled, directions enabled, clock kept by idle_run.
        setup(9'd0, 9'd31, 1'b0, 1'b0, 1'b0, 16'hFFFF);
        #1 port_en = 1'b0; idle_run = 1'b1;
        wait_fsync_rise();
        frame_counts(a, b, c, e);
        chk("R9 tx_ready with port off", b, 0);
        chk("R9 sd_out ones with port off", c, 0);
        chk("R9 rx_valid with port off", e, 0);

        // R5: gated, continuous and serial-clock-disabled behaviour.
        setup(9'd0, 9'd7, 1'b0, 1'b0, 1'b0, 16'h0);
        #1 tx_en = 1'b0; rx_en = 1'b0; idle_run = 1'b0;
        a = 0;
        repeat (100) begin @(negedge clk); a += int'(bclk | fsync); end
        chk("R5 gated idle clock high cycles", a, 0);
        idle_run = 1'b1;
        a = 0;
        repeat (100) begin @(negedge clk); a += int'(bclk); end
        chk("R5 continuous idle clock high cycles", a, 50);
        sclk_en = 1'b0; tx_en = 1'b1;
        @(negedge clk);
        a = 0;
        repeat (100) begin @(negedge clk); a += int'(bclk | fsync); end
        chk("R5 clock high cycles with sclk_en off", a, 0);

        // R4: divider change mid-frame waits for the frame boundary.
        setup(9'd1, 9'd31, 1'b0, 1'b0, 1'b0, 16'h0);
        wait_fsync_rise();
        bclk_div = 9'd3; sync_div = 9'd19;
        bclk_period(per);
        chk("R4 period kept within frame", per, 4);
        wait_fsync_rise();
        bclk_period(per);
        chk("R4 period after boundary", per, 8);
        frame_len(fl);
        chk("R4 frame length after boundary", fl, 20);

        finish_run();
    end
endmodule